// File: doc/BRIEF.md
# Software Reset Control Register

This block is a small memory-mapped control register that owns two reset sources for a subsystem built around a main processor and a DSP. A write that sets the global-reset field produces a one-cycle registered pulse on `glbRst`, which the surrounding logic uses to reset the main processor, the DSP and the peripheral clock domains. The global-reset field is not stored, so it always reads back as zero.

A second, sticky field drives `cfgRstN`. This active-low reset holds three DSP-side blocks in reset: the arbitration priority registers, the memory-controller configuration registers and the host-port control logic. The external reset pin forces the field to 0, which asserts `cfgRstN`. The field stays at 0 until software writes a 1 to it. Software can assert `cfgRstN` again by writing a 0. A global reset also returns the field to 0.

The register is a single write-only-strobe location. Every `regWe` cycle is a write to this register. The current contents are always visible on `regRdata`.

Top module: `swrst_ctrl`

## Requirements
- R1: While `extRstN` is low, and after it is released, `glbRst` is 0, `cfgRstN` is 0 and `regRdata` is 0.
- R2: A write with bit 3 of `regWdata` at 1 drives `glbRst` high for the one cycle after the write edge. `glbRst` returns to 0 on the next edge unless that edge is another such write.
- R3: No pulse appears on `glbRst` after a write with bit 3 at 0, or after a cycle with `regWe` low, whatever `regWdata` holds.
- R4: Bit 3 of `regRdata` is always 0, including while `glbRst` is high.
- R5: A write with bit 3 at 0 and bit 2 at 1 sets `cfgRstN` to 1 from the next cycle, and bit 2 of `regRdata` then reads 1.
- R6: A write with bit 3 at 0 and bit 2 at 0 sets `cfgRstN` back to 0 from the next cycle.
- R7: A write with bit 3 at 1 sets `cfgRstN` to 0 whatever bit 2 holds. So `cfgRstN` is 0 in every cycle in which `glbRst` is high.
- R8: The reserved bits 31:4 and 1:0 of `regRdata` always read 0. Values written to those bits have no effect on any output.
- R9: In a cycle with `regWe` low, `cfgRstN` keeps its value.
- R10: Taking `extRstN` low forces `cfgRstN` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| regWe | input | 1 | Write strobe for the register |
| regWdata | input | DATA_W (32) | Write data |
| regRdata | output | DATA_W (32) | Read data: bit 2 holds the sticky field, all other bits are 0 |
| glbRst | output | 1 | One-cycle global software reset pulse |
| cfgRstN | output | 1 | DSP-side configuration reset, active low |

## Verification
The stimulus writes each of the four combinations of bits 3 and 2, and checks that only bit 3 produces a pulse. It also checks that bit 3 overrides bit 2 when both are set.

Other sequences separate the stored field from the strobe decode:
- back-to-back global writes;
- a strobe-low cycle with bit 3 present on the data bus;
- writes with every reserved bit set.

An asynchronous pin reset in the middle of the run, taken while the field is released, shows that the pin clears the field without waiting for a clock edge.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // Strobes passed from the write decoder to the state datapath
  typedef struct packed {
    logic firePulse;  // request one global reset cycle
    logic cfgLoad;    // update the sticky DSP-side field
    logic cfgValue;   // value to load into it
  } swrst_strobe_t;

endpackage

// File: rtl/swrst_ctl.sv
module swrst_ctl
  import swrst_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GLB_BIT = 3,
  parameter int CFG_BIT = 2
) (
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output swrst_strobe_t     strobe
);

  logic glbReq;
  logic cfgReq;

  assign glbReq = regWe && regWdata[GLB_BIT];
  assign cfgReq = regWdata[CFG_BIT];

  always_comb begin
    strobe.firePulse = glbReq;
    strobe.cfgLoad   = regWe;
    // a global reset write overrides whatever the sticky field asks for
    strobe.cfgValue  = glbReq ? 1'b0 : cfgReq;
  end

endmodule

// File: rtl/swrst_dp.sv
module swrst_dp
  import swrst_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CFG_BIT = 2
) (
  input  logic              clk,
  input  logic              extRstN,
  input  swrst_strobe_t     strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              glbRst,
  output logic              cfgRstN
);

  logic pulseQ;
  logic cfgQ;

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      pulseQ <= 1'b0;
      cfgQ   <= 1'b0;
    end else begin
      pulseQ <= strobe.firePulse;
      if (strobe.cfgLoad) cfgQ <= strobe.cfgValue;
    end
  end

  // only the sticky field is readable; everything else reads 0
  always_comb begin
    regRdata          = '0;
    regRdata[CFG_BIT] = cfgQ;
  end

  assign glbRst  = pulseQ;
  assign cfgRstN = cfgQ;

endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
  parameter int DATA_W  = 32,
  parameter int GLB_BIT = 3,
  parameter int CFG_BIT = 2
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              glbRst,
  output logic              cfgRstN
);

  swrst_pkg::swrst_strobe_t strobe;

  swrst_ctl #(.DATA_W(DATA_W), .GLB_BIT(GLB_BIT), .CFG_BIT(CFG_BIT)) ctl_i (
    .regWe    (regWe),
    .regWdata (regWdata),
    .strobe   (strobe)
  );

  swrst_dp #(.DATA_W(DATA_W), .CFG_BIT(CFG_BIT)) dp_i (
    .clk      (clk),
    .extRstN  (extRstN),
    .strobe   (strobe),
    .regRdata (regRdata),
    .glbRst   (glbRst),
    .cfgRstN  (cfgRstN)
  );

endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int GLB_BIT = 3,
  parameter int CFG_BIT = 2
) (
  input logic              clk,
  input logic              extRstN,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              glbRst,
  input logic              cfgRstN
);

  localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'(1) << CFG_BIT);

  p_pulse_after_write_r2: assert property (@(posedge clk) disable iff (!extRstN)
    (regWe && regWdata[GLB_BIT]) |=> glbRst);

  p_pulse_source_r3: assert property (@(posedge clk) disable iff (!extRstN)
    glbRst |-> $past(regWe && regWdata[GLB_BIT]));

  p_glb_reads_zero_r4: assert property (@(posedge clk) disable iff (!extRstN)
    regRdata[GLB_BIT] == 1'b0);

  p_cfg_release_r5: assert property (@(posedge clk) disable iff (!extRstN)
    (regWe && !regWdata[GLB_BIT] && regWdata[CFG_BIT]) |=> cfgRstN);

  p_cfg_reassert_r6: assert property (@(posedge clk) disable iff (!extRstN)
    (regWe && !regWdata[GLB_BIT] && !regWdata[CFG_BIT]) |=> !cfgRstN);

  p_glb_clears_cfg_r7: assert property (@(posedge clk) disable iff (!extRstN)
    glbRst |-> !cfgRstN);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!extRstN)
    (regRdata & RSVD_MASK) == '0);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!extRstN)
    !regWe |=> $stable(cfgRstN));

endmodule

bind swrst_ctrl swrst_ctrl_chk #(.DATA_W(DATA_W), .GLB_BIT(GLB_BIT), .CFG_BIT(CFG_BIT)) chk_i (
  .clk      (clk),
  .extRstN  (extRstN),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .glbRst   (glbRst),
  .cfgRstN  (cfgRstN)
);

// File: tb/swrst_ctrl_tb_top.sv
`timescale 1ns/1ps
module swrst_ctrl_tb_top;

  localparam int DATA_W = 32;

  typedef struct {
    logic              glb;
    logic              cfg;
    logic [DATA_W-1:0] rd;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              extRstN = 1'b0;
  logic              regWe = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              glbRst;
  logic              cfgRstN;

  int   checks = 0;
  int   fails  = 0;
  logic modelCfg = 1'b0;
  bit   done = 1'b0;
  exp_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  swrst_ctrl #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .extRstN(extRstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .glbRst(glbRst), .cfgRstN(cfgRstN)
  );

  task automatic check(input string tag, input logic glbA, input logic cfgA,
                       input logic [DATA_W-1:0] rdA, input exp_t e);
    checks++;
    if (glbA !== e.glb || cfgA !== e.cfg || rdA !== e.rd) begin
      fails++;
      $display("FAIL %s: actual glb=%0b cfg=%0b rd=%h expected glb=%0b cfg=%0b rd=%h",
               tag, glbA, cfgA, rdA, e.glb, e.cfg, e.rd);
    end
  endtask

  // driver: one bus cycle, expected post-edge state pushed to the scoreboard
  task automatic step(input logic we, input logic [DATA_W-1:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    regWe    = we;
    regWdata = wd;
    e.glb = we && wd[3];
    if (we) modelCfg = wd[3] ? 1'b0 : wd[2];
    e.cfg = modelCfg;
    e.rd  = {{(DATA_W-3){1'b0}}, modelCfg, 2'b00};
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare just after the edge that produced the result
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, glbRst, cfgRstN, regRdata, e);
    end
  end

  initial begin
    exp_t z;
    z.glb = 1'b0; z.cfg = 1'b0; z.rd = '0; z.tag = "R1";
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", glbRst, cfgRstN, regRdata, z);
    @(negedge clk) extRstN = 1'b1;
    @(posedge clk) #1 check("R1 after release", glbRst, cfgRstN, regRdata, z);

    step(1'b0, 32'h0, "R9 idle");
    step(1'b1, 32'h4, "R5 release cfg");
    step(1'b0, 32'h0, "R9 hold released");
    step(1'b1, 32'hFFFF_FFF3, "R6 reassert with reserved set");
    step(1'b1, 32'hFFFF_FFF7, "R8 reserved ignored");
    step(1'b1, 32'h8, "R2 pulse and R4 read zero");
    step(1'b0, 32'h0, "R2 single cycle");
    step(1'b1, 32'h4, "R5 release again");
    step(1'b1, 32'hC, "R7 global overrides cfg");
    step(1'b1, 32'h8, "R2 back to back");
    step(1'b0, 32'h0, "R2 pulse ends");
    step(1'b1, 32'h4, "R5 release");
    step(1'b0, 32'hFFFF_FFFB, "R3 strobe low no pulse");
    step(1'b1, 32'h7, "R3 bit3 clear no pulse");
    step(1'b0, 32'h0, "R9 idle hold");

    // R10: asynchronous pin reset while the field is released
    @(posedge clk); #1;
    @(negedge clk);
    regWe = 1'b0;
    #0.5 extRstN = 1'b0;
    modelCfg = 1'b0;
    #0.5 check("R10 async clear", glbRst, cfgRstN, regRdata, z);
    @(negedge clk) extRstN = 1'b1;
    step(1'b0, 32'h0, "R10 stays cleared");
    step(1'b1, 32'h4, "R5 after pin reset");
    @(posedge clk); #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule